// File: doc/BRIEF.md
# Scan-Chain Framed SPI Bridge

This block is a user data register that hangs off a JTAG TAP and turns one DR-shift burst into a single SPI flash transaction. The host shifts a stream into TDI. The stream starts with some number of zero bits, which come from bypass registers in front of the bridge. A single 1 bit follows as the start marker, then a 32-bit length header, then the payload. The bridge asserts chip select for exactly the number of SPI clock cycles the header gives, forwards TDI to MOSI during that window, and returns MISO through its own one-bit scan register to TDO. The framing travels in-band, so the bridge needs no knowledge of how many TAPs are bypassed ahead of it or behind it.

A framing state machine has four states. `ST_HUNT` skips zeros. `ST_HEADER` collects the length, most significant bit first. `ST_DATA` drives the SPI bus. `ST_DONE` ignores everything until the next restart. The transitions are:
- HUNT→HEADER when a 1 is shifted in.
- HEADER→DATA after the last header bit, if the length is nonzero.
- HEADER→DONE after the last header bit, if the length is zero.
- DATA→DONE when the final counted cycle is shifted.
- Any state→HUNT on a capture strobe, an update strobe, or when select is low.

The SPI side runs in mode 0. SCLK is TCK gated to the data window. Chip select and the clock gate are retimed on the falling TCK edge. MISO is sampled on the rising edge.

Top module: `jspi_bridge`

## Requirements
- R1: Outside `ST_DATA`, the bridge is a one-bit scan register: TDO shows the TDI value sampled on the previous rising TCK edge.
- R2: While hunting, zero bits are skipped. The first 1 bit is the start marker. It produces no SCLK pulse and does not assert chip select, whatever the number of zeros ahead of it.
- R3: The 32 bits after the marker are taken as the transaction length N, most significant bit first. SCLK stays idle during these 32 cycles.
- R4: Chip select is low only in `ST_DATA`, for exactly N TCK cycles, and exactly N SCLK rising edges are produced.
- R5: During the data window MOSI carries TDI. The k-th data bit after the header is on MOSI at the k-th SCLK rising edge.
- R6: In `ST_DATA`, MISO is sampled on each rising TCK edge into the one-bit register that drives TDO.
- R7: After N cycles, chip select returns high and the block stays in `ST_DONE`. Further shift cycles cause no SCLK activity, and TDO returns to the one-bit scan path of R1.
- R8: A length of zero moves the block from `ST_HEADER` to `ST_DONE` without asserting chip select.
- R9: A capture strobe, an update strobe, or select going low returns the block to `ST_HUNT`. Select going low raises chip select at once and stops SCLK.
- R10: SPI mode 0 holds: SCLK is low whenever chip select is high, and chip select falls on a falling TCK edge before the first SCLK rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock, also the source of SCLK |
| dr_sel | input | 1 | This data register is selected by the TAP |
| dr_capture | input | 1 | TAP is in Capture-DR |
| dr_update | input | 1 | TAP is in Update-DR |
| dr_shift | input | 1 | TAP is in Shift-DR |
| tdi | input | 1 | Scan data in |
| tdo | output | 1 | Scan data out (one-bit register) |
| spi_sclk | output | 1 | SPI clock, TCK gated to the data window |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to flash |
| spi_miso | input | 1 | SPI data from flash |

## Verification
The bench builds the bridge with the default 32-bit header width, which is the width the host framing uses. It places 0, 1 or 3 emulated bypass registers ahead of the bridge. Each bypass register samples on the rising edge and presents its output on the falling edge, as a real TAP does. This exercises marker hunting after a variable run of zeros, and checks the round-trip offset of echoed MISO bits. Lengths of 0, 5, 8, 16 and 40 are used. The 40-cycle case is cut short by dropping select mid-transfer, which covers restart from inside the data window.

// File: rtl/jspi_pkg.sv
package jspi_pkg;

    // Framing phases of the in-band scan stream
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_HEADER = 2'd1,
        ST_DATA   = 2'd2,
        ST_DONE   = 2'd3
    } jspi_state_e;

endpackage

// File: rtl/jspi_framer.sv
// Marker hunt, length header capture and data-cycle countdown.
module jspi_framer
    import jspi_pkg::*;
#(
    parameter int HDR_W = 32
) (
    input  logic                     tck,
    input  logic                     dr_sel,
    input  logic                     dr_capture,
    input  logic                     dr_update,
    input  logic                     dr_shift,
    input  logic                     tdi,
    output jspi_state_e              state_o,
    output logic [$clog2(HDR_W)-1:0] hcnt_o,
    output logic [HDR_W-1:0]         hdr_o
);

    localparam int                CNT_W     = $clog2(HDR_W);
    localparam logic [CNT_W-1:0]  HCNT_LAST = CNT_W'(HDR_W - 1);
    localparam logic [HDR_W-1:0]  LEN_ONE   = HDR_W'(1);

    jspi_state_e      state_q;
    jspi_state_e      state_d;
    logic [HDR_W-1:0] hdr_q;
    logic [HDR_W-1:0] remain_q;
    logic [HDR_W-1:0] hdr_shifted;
    logic [CNT_W-1:0] hcnt_q;
    logic             restart;
    logic             hdr_last;
    logic             len_zero;
    logic             data_last;

    assign restart     = !dr_sel || dr_capture || dr_update;
    assign hdr_shifted = {hdr_q[HDR_W-2:0], tdi};
    assign hdr_last    = (hcnt_q == HCNT_LAST);
    assign len_zero    = (hdr_shifted == '0);
    assign data_last   = (remain_q == LEN_ONE);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = ST_HUNT;
        end else if (dr_shift) begin
            unique case (state_q)
                ST_HUNT:   if (tdi)       state_d = ST_HEADER;
                ST_HEADER: if (hdr_last)  state_d = len_zero ? ST_DONE : ST_DATA;
                ST_DATA:   if (data_last) state_d = ST_DONE;
                ST_DONE:   state_d = ST_DONE;
                default:   state_d = ST_HUNT;
            endcase
        end
    end

    // State register
    always_ff @(posedge tck) begin
        state_q <= state_d;
    end

    // Header shifter and cycle countdown
    always_ff @(posedge tck) begin
        if (restart) begin
            hcnt_q   <= '0;
            hdr_q    <= '0;
            remain_q <= '0;
        end else if (dr_shift) begin
            if (state_q == ST_HEADER) begin
                hdr_q  <= hdr_shifted;
                hcnt_q <= hcnt_q + 1'b1;
                if (hdr_last) begin
                    remain_q <= hdr_shifted;
                end
            end else if (state_q == ST_DATA) begin
                remain_q <= remain_q - LEN_ONE;
            end
        end
    end

    assign state_o = state_q;
    assign hcnt_o  = hcnt_q;
    assign hdr_o   = hdr_q;

endmodule

// File: rtl/jspi_spi_phy.sv
// Mode-0 SPI pins: falling-edge retimed select and clock gate.
module jspi_spi_phy (
    input  logic tck,
    input  logic dr_sel,
    input  logic dr_shift,
    input  logic in_data,
    input  logic tdi,
    output logic spi_sclk,
    output logic spi_cs_n,
    output logic spi_mosi
);

    logic cs_q;
    logic gate_q;

    // Retime on the low phase so the gated clock never glitches
    always_ff @(negedge tck) begin
        cs_q   <= !in_data;
        gate_q <= in_data && dr_shift;
    end

    assign spi_cs_n = cs_q | !dr_sel;
    assign spi_sclk = tck & gate_q & dr_sel;
    assign spi_mosi = !spi_cs_n & tdi;

endmodule

// File: rtl/jspi_tdo_stage.sv
// The single scan bit: TDI outside the data window, MISO inside it.
module jspi_tdo_stage (
    input  logic tck,
    input  logic in_data,
    input  logic tdi,
    input  logic spi_miso,
    output logic tdo
);

    logic bit_q;

    always_ff @(posedge tck) begin
        bit_q <= in_data ? spi_miso : tdi;
    end

    assign tdo = bit_q;

endmodule

// File: rtl/jspi_bridge.sv
module jspi_bridge
    import jspi_pkg::*;
#(
    parameter int HDR_W = 32
) (
    input  logic tck,
    input  logic dr_sel,
    input  logic dr_capture,
    input  logic dr_update,
    input  logic dr_shift,
    input  logic tdi,
    output logic tdo,
    output logic spi_sclk,
    output logic spi_cs_n,
    output logic spi_mosi,
    input  logic spi_miso
);

    localparam int CNT_W = $clog2(HDR_W);

    jspi_state_e      state;
    logic [CNT_W-1:0] hcnt;
    logic [HDR_W-1:0] hdr;
    logic             in_data;

    assign in_data = (state == ST_DATA);

    jspi_framer #(.HDR_W(HDR_W)) u_framer (
        .tck        (tck),
        .dr_sel     (dr_sel),
        .dr_capture (dr_capture),
        .dr_update  (dr_update),
        .dr_shift   (dr_shift),
        .tdi        (tdi),
        .state_o    (state),
        .hcnt_o     (hcnt),
        .hdr_o      (hdr)
    );

    jspi_spi_phy u_phy (
        .tck      (tck),
        .dr_sel   (dr_sel),
        .dr_shift (dr_shift),
        .in_data  (in_data),
        .tdi      (tdi),
        .spi_sclk (spi_sclk),
        .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi)
    );

    jspi_tdo_stage u_tdo (
        .tck      (tck),
        .in_data  (in_data),
        .tdi      (tdi),
        .spi_miso (spi_miso),
        .tdo      (tdo)
    );

endmodule

// File: rtl/jspi_bridge_chk.sv
module jspi_bridge_chk
    import jspi_pkg::*;
#(
    parameter int HDR_W = 32
) (
    input logic                     tck,
    input logic                     dr_sel,
    input logic                     dr_capture,
    input logic                     dr_update,
    input logic                     dr_shift,
    input logic                     tdi,
    input logic                     tdo,
    input logic                     spi_cs_n,
    input logic                     spi_miso,
    input jspi_state_e              state,
    input logic [$clog2(HDR_W)-1:0] hcnt,
    input logic [HDR_W-1:0]         hdr
);

    localparam int               CNT_W = $clog2(HDR_W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(HDR_W - 1);

    logic hold;
    assign hold = !dr_capture && !dr_update;

    // R1: one-bit scan path outside the data window
    p_bypass_r1: assert property (@(posedge tck) disable iff (!dr_sel)
        (state != ST_DATA) |=> (tdo == $past(tdi)));

    // R2: zeros keep hunting, a one is taken as the marker
    p_hunt_r2: assert property (@(posedge tck) disable iff (!dr_sel)
        (state == ST_HUNT && dr_shift && !tdi && hold) |=> (state == ST_HUNT));
    p_marker_r2: assert property (@(posedge tck) disable iff (!dr_sel)
        (state == ST_HUNT && dr_shift && tdi && hold) |=> (state == ST_HEADER));

    // R3: header phase lasts until the last header bit
    p_header_r3: assert property (@(posedge tck) disable iff (!dr_sel)
        (state == ST_HEADER && dr_shift && hcnt != LAST && hold) |=> (state == ST_HEADER));

    // R4: chip select low only in the data phase
    p_cs_idle_r4: assert property (@(posedge tck) disable iff (!dr_sel)
        (state != ST_DATA) |-> spi_cs_n);

    // R6: MISO lands in the scan bit during data
    p_miso_r6: assert property (@(posedge tck) disable iff (!dr_sel)
        (state == ST_DATA) |=> (tdo == $past(spi_miso)));

    // R7: done is sticky until a restart
    p_done_r7: assert property (@(posedge tck) disable iff (!dr_sel)
        (state == ST_DONE && hold) |=> (state == ST_DONE && spi_cs_n));

    // R8: zero length skips the data phase
    p_zero_len_r8: assert property (@(posedge tck) disable iff (!dr_sel)
        (state == ST_HEADER && dr_shift && hcnt == LAST && hold &&
         {hdr[HDR_W-2:0], tdi} == '0) |=> (state == ST_DONE && spi_cs_n));

    // R9: capture or update restarts the hunt
    p_restart_r9: assert property (@(posedge tck) disable iff (!dr_sel)
        (dr_capture || dr_update) |=> (state == ST_HUNT));

endmodule

bind jspi_bridge jspi_bridge_chk #(.HDR_W(HDR_W)) u_chk (
    .tck        (tck),
    .dr_sel     (dr_sel),
    .dr_capture (dr_capture),
    .dr_update  (dr_update),
    .dr_shift   (dr_shift),
    .tdi        (tdi),
    .tdo        (tdo),
    .spi_cs_n   (spi_cs_n),
    .spi_miso   (spi_miso),
    .state      (state),
    .hcnt       (hcnt),
    .hdr        (hdr)
);

// File: tb/jspi_bridge_bench.sv
module jspi_bridge_bench;

    localparam logic [15:0] PAT = 16'hA5C3;

    logic tck = 1'b0;
    always #5 tck = ~tck;

    logic dr_sel = 1'b0;
    logic dr_capture = 1'b0;
    logic dr_update = 1'b0;
    logic dr_shift = 1'b0;
    logic host_tdi = 1'b0;
    logic tdo, spi_sclk, spi_cs_n, spi_mosi, spi_miso;
    logic dut_tdi;

    int n_checks = 0;
    int n_fail = 0;
    int nbyp = 0;

    // Emulated upstream bypass TAPs: sample on rise, present on fall
    logic [2:0] bp_pos;
    logic [2:0] bp_out;
    logic [3:0] chain;
    assign chain = {bp_out, host_tdi};
    always @(posedge tck) begin
        if (dr_capture) bp_pos <= '0;
        else            bp_pos <= chain[2:0];
    end
    always @(negedge tck) bp_out <= bp_pos;
    assign dut_tdi = chain[nbyp];

    jspi_bridge u_jspi_bridge (
        .tck        (tck),
        .dr_sel     (dr_sel),
        .dr_capture (dr_capture),
        .dr_update  (dr_update),
        .dr_shift   (dr_shift),
        .tdi        (dut_tdi),
        .tdo        (tdo),
        .spi_sclk   (spi_sclk),
        .spi_cs_n   (spi_cs_n),
        .spi_mosi   (spi_mosi),
        .spi_miso   (spi_miso)
    );

    // SPI slave model: echoes PAT, records MOSI
    int   slave_idx = 0;
    int   mosi_cnt = 0;
    int   sclk_cnt = 0;
    int   sclk_idle = 0;
    int   cs_lo_cyc = 0;
    int   cs_falls = 0;
    logic mosi_rec [0:127];
    logic tdo_rec  [0:127];

    assign spi_miso = PAT[slave_idx % 16];
    always @(negedge spi_cs_n) begin
        slave_idx = 0;
        cs_falls++;
    end
    always @(negedge spi_sclk) slave_idx++;
    always @(posedge spi_sclk) begin
        sclk_cnt++;
        if (spi_cs_n) sclk_idle++;
        else if (mosi_cnt < 128) begin
            mosi_rec[mosi_cnt] = spi_mosi;
            mosi_cnt++;
        end
    end
    always @(posedge tck) if (!spi_cs_n) cs_lo_cyc++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic host_bit(input int c, input int n, input logic [63:0] dat);
        if (c == 0) return 1'b1;
        if (c <= 32) return n[32-c];
        if (c < 33 + n) return dat[c-33];
        return 1'b1;
    endfunction

    // One framed transfer; abort_at >= 0 drops select at that host cycle
    task automatic run_xfer(input int byp, input int n, input logic [63:0] dat, input int abort_at);
        int total;
        int bad;
        total = 33 + n + byp + 4;
        nbyp = byp;
        mosi_cnt = 0; sclk_cnt = 0; sclk_idle = 0; cs_lo_cyc = 0; cs_falls = 0;
        @(negedge tck); #1;
        dr_sel = 1'b1; dr_capture = 1'b1;
        @(negedge tck); #1;
        dr_capture = 1'b0; dr_shift = 1'b1;
        for (int c = 0; c < total; c++) begin
            host_tdi = host_bit(c, n, dat);
            if (c == abort_at) dr_sel = 1'b0;
            @(posedge tck);
            @(negedge tck); #1;
            tdo_rec[c] = tdo;
            if (c == abort_at) begin
                chk(spi_cs_n == 1'b1, "R9 cs high after select drop", int'(spi_cs_n), 1);
                break;
            end
        end
        dr_shift = 1'b0; host_tdi = 1'b0;
        if (abort_at >= 0) begin
            repeat (3) @(negedge tck);
            chk(sclk_cnt == abort_at - 33, "R9 sclk stops on abort", sclk_cnt, abort_at - 33);
            #1 dr_sel = 1'b1;
            return;
        end
        dr_update = 1'b1;
        @(negedge tck); #1;
        dr_update = 1'b0;
        // R2: zeros ahead of the marker pass as zeros
        bad = 0;
        for (int c = 0; c < byp; c++) if (tdo_rec[c] !== 1'b0) bad++;
        chk(bad == 0, "R2 leading zeros", bad, 0);
        // R1: header bits echo one cycle later
        bad = 0;
        for (int c = byp; c <= byp + 32; c++)
            if (tdo_rec[c] !== host_bit(c - byp, n, dat)) bad++;
        chk(bad == 0, "R1 scan path during header", bad, 0);
        // R3/R4: cycle count and chip select width
        chk(sclk_cnt == n, "R3 R4 sclk pulses", sclk_cnt, n);
        chk(cs_lo_cyc == n, "R4 cs low width", cs_lo_cyc, n);
        chk(cs_falls == (n > 0 ? 1 : 0), "R8 R4 cs assertions", cs_falls, n > 0 ? 1 : 0);
        // R5: MOSI bits
        bad = 0;
        for (int j = 0; j < n; j++) if (mosi_rec[j] !== dat[j]) bad++;
        chk(mosi_cnt == n && bad == 0, "R5 mosi bits", bad, 0);
        // R6: echoed MISO on TDO
        bad = 0;
        for (int j = 0; j < n; j++) if (tdo_rec[byp + 33 + j] !== PAT[j % 16]) bad++;
        chk(bad == 0, "R6 miso on tdo", bad, 0);
        // R7: trailing ones ignored, scan path restored
        chk(tdo_rec[total-1] === 1'b1 && spi_cs_n, "R7 trailing bits", int'(tdo_rec[total-1]), 1);
        chk(sclk_idle == 0, "R10 sclk idle with cs high", sclk_idle, 0);
    endtask

    task automatic test_reset();
        repeat (4) @(negedge tck);
        #1;
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && spi_mosi == 1'b0,
            "R9 R10 idle pins", {29'd0, spi_cs_n, spi_sclk, spi_mosi}, 4);
    endtask

    initial begin
        #(200_000 * 10);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        run_xfer(0, 8,  64'h3C, -1);
        run_xfer(1, 16, 64'hBEEF, -1);
        run_xfer(3, 5,  64'h15, -1);
        run_xfer(1, 0,  64'h0, -1);     // R8 zero length
        run_xfer(0, 40, 64'h12_3456_789A, 38);
        run_xfer(0, 8,  64'hC5, -1);    // R9 clean restart after abort
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule